// File: doc/BRIEF.md
# Anti-Rollback Fuse Count Checker

This block is a boot-time sequencer that refuses to run older firmware. It reads one one-time-programmable fuse word through a request/acknowledge port to the fuse controller and counts its set bits. It then compares that count with a minimum taken from the firmware version index and the unit type. A count above the minimum halts the boot with a panic flag. A matching count lets the boot continue, and the block raises a done flag.

A count below the minimum makes the sequencer raise the programming enable and burn the required pattern into two fuse words. It then drops the enable, leaves a marker byte in a scratch register that survives the reboot, and holds a watchdog reset request. On the next boot the reset cause reads as a watchdog reset. The sequencer then accepts the boot only if the recount matches and the marker is present. In that case it pulses a clear of the reset cause.

Top module: `arb_seq`

## Requirements
- R1: While rst_ni is low, and after reset until start_i, all outputs are 0.
- R2: After a start_i pulse, the block issues a read command (fc_cmd_o = 1) to fuse word 0x3C. The burnt-bit count is the number of 1 bits in the returned word, whatever their positions.
- R3: Bits 1:0 of cfg_i give the unit type. Only 0 means retail, and retail expects version index v+1 (1, 2, 3, 4). Any other value expects 0, 0, 1, 1 for v = 0..3. ver_i and cfg_i are sampled when start_i is seen.
- R4: When the reset cause is not 1 and the count exceeds the expected value, panic_o rises. No program command, scratch write or watchdog request follows.
- R5: When the reset cause is not 1 and the count equals the expected value, done_o rises. No program command and no reset-cause clear follows.
- R6: When the reset cause is not 1 and the count is below the expected value E, the block issues two program commands (fc_cmd_o = 2): the first to word 0x3A and the second to word 0x3C, each with data (1<<E)-1. It then writes 0x21 to the scratch register and holds wdt_rst_o high.
- R7: Every program command is issued with prog_en_o high. prog_en_o is low again before the scratch write and stays low afterwards.
- R8: When the reset cause is 1 (watchdog), the count equals the expected value and the scratch register reads 0x21, the block gives a one-cycle rst_clr_o pulse and then raises done_o.
- R9: When the reset cause is 1 and either the marker is missing or the count differs from the expected value, panic_o rises with no clear and no burn.
- R10: panic_o, done_o and wdt_rst_o are never high together. Once high, each stays high until reset, and later start_i pulses do not affect them.
- R11: A fuse command holds fc_req_o, fc_cmd_o, fc_addr_o and fc_wdata_o steady until fc_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the boot check (pulse) |
| ver_i | input | VER_W | Firmware version index |
| cfg_i | input | FUSE_W | Configuration word; bits 1:0 give the unit type |
| rst_stat_i | input | ST_W | Reset cause (1 = watchdog) |
| scr_rdata_i | input | SCR_W | Scratch register read value |
| fc_ack_i | input | 1 | Fuse controller acknowledge; read data valid |
| fc_rdata_i | input | FUSE_W | Fuse read data |
| fc_req_o | output | 1 | Fuse command request |
| fc_cmd_o | output | 2 | 1 = read, 2 = program |
| fc_addr_o | output | ADDR_W | Fuse word index |
| fc_wdata_o | output | FUSE_W | Program data |
| prog_en_o | output | 1 | Fuse programming enable |
| scr_we_o | output | 1 | Scratch write strobe |
| scr_wdata_o | output | SCR_W | Scratch write data |
| rst_clr_o | output | 1 | Clear the reset cause to power-on (pulse) |
| wdt_rst_o | output | 1 | Watchdog reset request (held) |
| panic_o | output | 1 | Boot refused |
| done_o | output | 1 | Boot accepted |

## Verification
A wrong internal state shows up at the ports within a few cycles of the read acknowledge. A bad count or a bad table entry flips the outcome between panic, done and burn. A wrong burn pattern appears directly on fc_wdata_o in the two program commands. Reboots are modelled with fuse and scratch contents kept across reset, so a mistake in the marker or reset-cause logic shows up on the second boot as a missing or extra rst_clr_o pulse, or as a panic. The sweep covers every version index, three unit codes, each starting count from 0 to 4, and two acknowledge latencies.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_READ, S_EVAL, S_PGM_ON, S_WR_LO, S_WR_HI,
    S_PGM_OFF, S_MARK, S_WDT, S_CLR, S_DONE, S_PANIC
  } arb_state_e;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_READ = 2'd1;
  localparam logic [1:0] CMD_PROG = 2'd2;
endpackage

// File: rtl/arb_popcount.sv
module arb_popcount #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     word_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CNT_W'(word_i[i]);
  end
endmodule

// File: rtl/arb_expect.sv
module arb_expect #(
  parameter int W     = 32,
  parameter int VER_W = 2,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [VER_W-1:0] ver_i,
  input  logic             retail_i,
  output logic [CNT_W-1:0] exp_o,
  output logic [W-1:0]     pat_o
);
  // retail: one extra fuse per version step; others: one per two steps
  always_comb begin
    if (retail_i) exp_o = CNT_W'(ver_i) + CNT_W'(1);
    else          exp_o = CNT_W'(ver_i >> 1);
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_therm
      assign pat_o[g] = (CNT_W'(g) < exp_o);
    end
  endgenerate
endmodule

// File: rtl/arb_seq.sv
module arb_seq #(
  parameter int                FUSE_W  = 32,
  parameter int                ADDR_W  = 8,
  parameter int                VER_W   = 2,
  parameter int                SCR_W   = 8,
  parameter int                ST_W    = 2,
  parameter logic [ADDR_W-1:0] WORD_LO = 8'h3A,
  parameter logic [ADDR_W-1:0] WORD_HI = 8'h3C,
  parameter logic [SCR_W-1:0]  MARKER  = 8'h21,
  parameter logic [ST_W-1:0]   ST_WDT  = 2'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VER_W-1:0]  ver_i,
  input  logic [FUSE_W-1:0] cfg_i,
  input  logic [ST_W-1:0]   rst_stat_i,
  input  logic [SCR_W-1:0]  scr_rdata_i,
  input  logic              fc_ack_i,
  input  logic [FUSE_W-1:0] fc_rdata_i,
  output logic              fc_req_o,
  output logic [1:0]        fc_cmd_o,
  output logic [ADDR_W-1:0] fc_addr_o,
  output logic [FUSE_W-1:0] fc_wdata_o,
  output logic              prog_en_o,
  output logic              scr_we_o,
  output logic [SCR_W-1:0]  scr_wdata_o,
  output logic              rst_clr_o,
  output logic              wdt_rst_o,
  output logic              panic_o,
  output logic              done_o
);
  import arb_pkg::*;

  localparam int CNT_W = $clog2(FUSE_W + 1);

  arb_state_e        state_q, state_d;
  logic [FUSE_W-1:0] word_q;
  logic [VER_W-1:0]  ver_q;
  logic              retail_q;
  logic [CNT_W-1:0]  cnt, exp_cnt;
  logic [FUSE_W-1:0] pat;
  logic              wdt_boot;

  arb_popcount #(.W(FUSE_W), .CNT_W(CNT_W)) u_pop (
    .word_i (word_q),
    .cnt_o  (cnt)
  );

  arb_expect #(.W(FUSE_W), .VER_W(VER_W), .CNT_W(CNT_W)) u_exp (
    .ver_i    (ver_q),
    .retail_i (retail_q),
    .exp_o    (exp_cnt),
    .pat_o    (pat)
  );

  assign wdt_boot = (rst_stat_i == ST_WDT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      word_q   <= '0;
      ver_q    <= '0;
      retail_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        ver_q    <= ver_i;
        retail_q <= (cfg_i[1:0] == 2'b00);
      end
      if (state_q == S_READ && fc_ack_i) word_q <= fc_rdata_i;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (start_i) state_d = S_READ;
      S_READ:    if (fc_ack_i) state_d = S_EVAL;
      S_EVAL: begin
        if (wdt_boot) begin
          // second boot: proof of update required
          if (cnt == exp_cnt && scr_rdata_i == MARKER) state_d = S_CLR;
          else                                          state_d = S_PANIC;
        end else if (cnt > exp_cnt)  state_d = S_PANIC;
        else if (cnt == exp_cnt)     state_d = S_DONE;
        else                         state_d = S_PGM_ON;
      end
      S_PGM_ON:  state_d = S_WR_LO;
      S_WR_LO:   if (fc_ack_i) state_d = S_WR_HI;
      S_WR_HI:   if (fc_ack_i) state_d = S_PGM_OFF;
      S_PGM_OFF: state_d = S_MARK;
      S_MARK:    state_d = S_WDT;
      S_CLR:     state_d = S_DONE;
      S_WDT, S_DONE, S_PANIC: state_d = state_q;
      default:   state_d = S_IDLE;
    endcase
  end

  always_comb begin
    fc_req_o    = 1'b0;
    fc_cmd_o    = CMD_NONE;
    fc_addr_o   = '0;
    fc_wdata_o  = '0;
    case (state_q)
      S_READ: begin
        fc_req_o  = 1'b1;
        fc_cmd_o  = CMD_READ;
        fc_addr_o = WORD_HI;
      end
      S_WR_LO: begin
        fc_req_o   = 1'b1;
        fc_cmd_o   = CMD_PROG;
        fc_addr_o  = WORD_LO;
        fc_wdata_o = pat;
      end
      S_WR_HI: begin
        fc_req_o   = 1'b1;
        fc_cmd_o   = CMD_PROG;
        fc_addr_o  = WORD_HI;
        fc_wdata_o = pat;
      end
      default: ;
    endcase
  end

  assign prog_en_o   = (state_q == S_PGM_ON) || (state_q == S_WR_LO) || (state_q == S_WR_HI);
  assign scr_we_o    = (state_q == S_MARK);
  assign scr_wdata_o = (state_q == S_MARK) ? MARKER : '0;
  assign rst_clr_o   = (state_q == S_CLR);
  assign wdt_rst_o   = (state_q == S_WDT);
  assign panic_o     = (state_q == S_PANIC);
  assign done_o      = (state_q == S_DONE);
endmodule

// File: rtl/arb_seq_chk.sv
module arb_seq_chk #(
  parameter int              ADDR_W = 8,
  parameter int              FUSE_W = 32,
  parameter int              ST_W   = 2,
  parameter logic [ST_W-1:0] ST_WDT = 2'd1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fc_req_o,
  input logic              fc_ack_i,
  input logic [1:0]        fc_cmd_o,
  input logic [ADDR_W-1:0] fc_addr_o,
  input logic [FUSE_W-1:0] fc_wdata_o,
  input logic              prog_en_o,
  input logic              scr_we_o,
  input logic              rst_clr_o,
  input logic [ST_W-1:0]   rst_stat_i,
  input logic              wdt_rst_o,
  input logic              panic_o,
  input logic              done_o
);
  // R7
  pgm_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_req_o && fc_cmd_o == 2'd2) |-> prog_en_o);
  // R7
  mark_after_pgm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scr_we_o |-> !prog_en_o);
  // R10
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({panic_o, done_o, wdt_rst_o}) <= 1);
  // R10
  panic_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panic_o |=> panic_o);
  // R10
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R10
  wdt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> wdt_rst_o);
  // R8
  clr_on_wdt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_clr_o |-> (rst_stat_i == ST_WDT));
  // R8
  clr_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_clr_o |=> done_o);
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_req_o && !fc_ack_i) |=> (fc_req_o && $stable(fc_addr_o) && $stable(fc_cmd_o)
                                 && $stable(fc_wdata_o)));
endmodule

bind arb_seq arb_seq_chk #(
  .ADDR_W(ADDR_W), .FUSE_W(FUSE_W), .ST_W(ST_W), .ST_WDT(ST_WDT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fc_req_o(fc_req_o), .fc_ack_i(fc_ack_i),
  .fc_cmd_o(fc_cmd_o), .fc_addr_o(fc_addr_o), .fc_wdata_o(fc_wdata_o),
  .prog_en_o(prog_en_o), .scr_we_o(scr_we_o), .rst_clr_o(rst_clr_o),
  .rst_stat_i(rst_stat_i), .wdt_rst_o(wdt_rst_o), .panic_o(panic_o), .done_o(done_o)
);

// File: tb/arb_seq_bench.sv
module arb_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, load = 1'b0;
  logic [1:0]  ver = '0;
  logic [31:0] cfg = '0;
  logic [31:0] pre_a = '0, pre_b = '0;
  logic [7:0]  pre_scr = '0;
  logic [1:0]  pre_st = '0;
  int          dly_sel = 0;

  logic        fc_req, fc_ack, prog_en, scr_we, rst_clr, wdt_rst, panic, done;
  logic [1:0]  fc_cmd;
  logic [7:0]  fc_addr, scr_wdata;
  logic [31:0] fc_wdata, fc_rdata;

  // environment model: fuses, scratch and reset cause persist across rst_n
  logic [31:0] mem_a, mem_b;
  logic [7:0]  scratch;
  logic [1:0]  stat;
  int          dly_cnt, n_read, n_prog, n_scr, n_clr, pgm_bad, r11_bad;
  logic [7:0]  rd_addr, wr_addr0, wr_addr1;
  logic [31:0] wr_data0, wr_data1;
  logic        p_req, p_ack;
  logic [7:0]  p_addr;
  logic [31:0] p_wdata;

  arb_seq u_arb_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ver_i(ver), .cfg_i(cfg),
    .rst_stat_i(stat), .scr_rdata_i(scratch), .fc_ack_i(fc_ack), .fc_rdata_i(fc_rdata),
    .fc_req_o(fc_req), .fc_cmd_o(fc_cmd), .fc_addr_o(fc_addr), .fc_wdata_o(fc_wdata),
    .prog_en_o(prog_en), .scr_we_o(scr_we), .scr_wdata_o(scr_wdata), .rst_clr_o(rst_clr),
    .wdt_rst_o(wdt_rst), .panic_o(panic), .done_o(done)
  );

  always @(posedge clk) begin
    if (load) begin
      mem_a <= pre_a; mem_b <= pre_b; scratch <= pre_scr; stat <= pre_st;
      fc_ack <= 1'b0; fc_rdata <= '0; dly_cnt <= 0;
      n_read <= 0; n_prog <= 0; n_scr <= 0; n_clr <= 0; pgm_bad <= 0; r11_bad <= 0;
      rd_addr <= '0; wr_addr0 <= '0; wr_addr1 <= '0; wr_data0 <= '0; wr_data1 <= '0;
      p_req <= 1'b0; p_ack <= 1'b0; p_addr <= '0; p_wdata <= '0;
    end else begin
      p_req <= fc_req; p_ack <= fc_ack; p_addr <= fc_addr; p_wdata <= fc_wdata;
      if (p_req && !p_ack && (!fc_req || fc_addr != p_addr || fc_wdata != p_wdata))
        r11_bad <= r11_bad + 1;
      fc_ack <= 1'b0;
      if (fc_req && !fc_ack) begin
        if (dly_cnt >= dly_sel) begin
          dly_cnt <= 0;
          fc_ack  <= 1'b1;
          if (fc_cmd == 2'd1) begin
            n_read   <= n_read + 1;
            rd_addr  <= fc_addr;
            fc_rdata <= (fc_addr == 8'h3A) ? mem_a : (fc_addr == 8'h3C) ? mem_b : 32'h0;
          end else if (fc_cmd == 2'd2) begin
            if (!prog_en) pgm_bad <= pgm_bad + 1;
            if (n_prog == 0) begin wr_addr0 <= fc_addr; wr_data0 <= fc_wdata; end
            if (n_prog == 1) begin wr_addr1 <= fc_addr; wr_data1 <= fc_wdata; end
            n_prog <= n_prog + 1;
            if (prog_en && fc_addr == 8'h3A) mem_a <= mem_a | fc_wdata;
            if (prog_en && fc_addr == 8'h3C) mem_b <= mem_b | fc_wdata;
          end
        end else dly_cnt <= dly_cnt + 1;
      end
      if (scr_we) begin
        scratch <= scr_wdata; n_scr <= n_scr + 1;
        if (prog_en) pgm_bad <= pgm_bad + 1;
      end
      if (rst_clr) begin stat <= 2'd0; n_clr <= n_clr + 1; end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int expect_cnt(input logic [1:0] v, input logic [31:0] c);
    return (c[1:0] == 2'b00) ? int'(v) + 1 : int'(v) / 2;
  endfunction

  task automatic boot(input logic [31:0] a, input logic [31:0] b, input logic [7:0] s,
                      input logic [1:0] st, input logic [1:0] v, input logic [31:0] c,
                      input int d);
    @(negedge clk);
    rst_n = 1'b0; pre_a = a; pre_b = b; pre_scr = s; pre_st = st; dly_sel = d;
    ver = v; cfg = c; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    // R1
    chk({fc_req, prog_en, scr_we, rst_clr, wdt_rst, panic, done} == '0, "R1 reset",
        {fc_req, prog_en, scr_we, rst_clr, wdt_rst, panic, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ver = ~v; cfg = ~c;  // sampled values must be used
    for (int i = 0; i < 80 && !(done || panic || wdt_rst); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic sticky_check();
    logic [2:0] f0;
    f0 = {panic, done, wdt_rst};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R10
    chk({panic, done, wdt_rst} == f0 && $countones(f0) == 1, "R10 sticky", {panic, done, wdt_rst}, f0);
  endtask

  task automatic run_case(input logic [31:0] b, input logic [7:0] s, input logic [1:0] st,
                          input logic [1:0] v, input logic [31:0] c, input int d);
    int e, k;
    logic [31:0] pat;
    e = expect_cnt(v, c);
    k = $countones(b);
    pat = 32'((64'd1 << e) - 1);
    boot(b, b, s, st, v, c, d);
    // R2
    chk(n_read == 1 && rd_addr == 8'h3C, "R2 read word", rd_addr, 8'h3C);
    // R11
    chk(r11_bad == 0, "R11 hold until ack", r11_bad, 0);
    if (st == 2'd1) begin
      if (k == e && s == 8'h21) begin
        // R8
        chk(done && !panic && n_clr == 1 && stat == 0, "R8 accept after watchdog", {done, panic, 6'(n_clr)}, 8'h81);
      end else begin
        // R9
        chk(panic && !done && n_clr == 0 && n_prog == 0 && stat == 1, "R9 refuse after watchdog",
            {panic, done, 6'(n_clr)}, 8'h80);
      end
    end else if (k > e) begin
      // R4 R3
      chk(panic && !done && !wdt_rst && n_prog == 0 && n_scr == 0, "R4 R3 too many",
          {panic, done, wdt_rst, 5'(n_prog)}, 8'h80);
    end else if (k == e) begin
      // R5 R3
      chk(done && !panic && !wdt_rst && n_prog == 0 && n_clr == 0, "R5 R3 match",
          {panic, done, wdt_rst, 5'(n_prog)}, 8'h40);
    end else begin
      // R6 R3
      chk(wdt_rst && !panic && !done && n_prog == 2, "R6 R3 burn outcome",
          {panic, done, wdt_rst, 5'(n_prog)}, 8'h22);
      chk(wr_addr0 == 8'h3A && wr_addr1 == 8'h3C, "R6 burn order", {wr_addr0, wr_addr1}, 16'h3A3C);
      chk(wr_data0 == pat && wr_data1 == pat, "R6 burn pattern", wr_data1, pat);
      chk(n_scr == 1 && scratch == 8'h21, "R6 marker", scratch, 8'h21);
      // R7
      chk(pgm_bad == 0 && !prog_en, "R7 prog enable window", pgm_bad, 0);
      sticky_check();
      // reboot by watchdog; fuses and scratch persist
      boot(mem_a, mem_b, scratch, 2'd1, v, c, d);
      // R8
      chk(done && n_clr == 1 && stat == 0 && n_prog == 0, "R8 accept after burn", {done, 7'(n_clr)}, 8'h81);
    end
    sticky_check();
  endtask

  initial begin
    logic [31:0] units [3];
    units[0] = 32'h0; units[1] = 32'h3; units[2] = 32'h1;
    for (int u = 0; u < 3; u++)
      for (int v = 0; v < 4; v++)
        for (int k = 0; k <= 4; k++)
          run_case(32'((64'd1 << k) - 1), 8'h00, 2'd0, 2'(v), units[u], (u + v + k) % 2 * 2);
    // R2 scattered bits count as burnt
    run_case(32'h8000_0020, 8'h00, 2'd0, 2'd1, 32'hFFFF_FFFC, 1);
    run_case(32'h8000_0001, 8'h00, 2'd0, 2'd0, 32'h0, 0);
    // R9 corners
    run_case(32'h1, 8'h20, 2'd1, 2'd0, 32'h0, 0);
    run_case(32'h1, 8'h21, 2'd1, 2'd1, 32'h0, 2);
    run_case(32'h7, 8'h21, 2'd1, 2'd0, 32'h0, 0);
    // R8 direct; R5 with other non-watchdog cause
    run_case(32'h3, 8'h21, 2'd1, 2'd1, 32'h0, 0);
    run_case(32'h3, 8'h00, 2'd2, 2'd1, 32'h0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule